// File: doc/BRIEF.md
# Quantized Complex Size-Reduction Unit

This unit carries out one size-reduction step of lattice reduction on an upper-triangular channel matrix. A request carries two complex columns of R: the column being reduced (k) and an earlier column (l). It also carries the matching complex columns of the unimodular transform T, and the row index of column l's diagonal. The unit reads two values out of these columns. The pivot is the real part of column l at the pivot row. The off-diagonal entry is column k at the pivot row. From these it forms the projection coefficient as a small Gaussian integer. It then subtracts that coefficient times column l from column k in both R and T.

The coefficient is never formed as a number. For each of the real and imaginary parts, the unit compares the magnitude of the off-diagonal component against one half and three halves of the pivot magnitude. These two threshold bits, together with a sign bit, steer shift-and-negate multiplexers in the update lanes. Three lanes work in parallel: the real part of R, the imaginary part of R, and the complex T column. R entries are 16-bit signed fixed point. T entries are 8-bit signed integers. All results saturate. A full reduction of column k is built by issuing one request per earlier column in turn.

The result is registered and presented the cycle after acceptance, behind a valid/ready pair.

Top module: `szr_unit`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: Each coefficient component has magnitude 0 when 2|x| <= |p|, magnitude 1 when |p| < 2|x| <= 3|p|, and magnitude 2 otherwise. Here x is the real or imaginary part of the off-diagonal entry and p is the pivot. The sign is negative exactly when the sign bits of x and p differ. The real and imaginary components are decided independently.
- R3: For each updated row of R, the new real part is a_re - (mr*b_re - mi*b_im). Here a is the column-k entry, b is the column-l entry, and mr, mi are the coefficient components.
- R4: For each updated row of R, the new imaginary part is a_im - (mr*b_im + mi*b_re).
- R5: R rows with an index greater than piv_idx leave the unit unchanged. Rows 0 to piv_idx are updated.
- R6: Every row of the T column is updated with the same coefficient and the same formulas as R3 and R4.
- R7: Results outside the signed range of their lane clamp to the most positive or most negative value: 16 bits for R, 8 bits for T.
- R8: A request accepted at one clock edge has its result on the outputs with out_valid high after that edge. If out_ready is high and nothing new is accepted, out_valid drops after the next edge.
- R9: While out_valid is high and out_ready is low, the outputs hold and in_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| piv_idx | input | 2 | Row index of column l's diagonal |
| rk_re | input | 64 | Column k of R, real parts, row r at bits r*16 |
| rk_im | input | 64 | Column k of R, imaginary parts |
| rl_re | input | 64 | Column l of R, real parts |
| rl_im | input | 64 | Column l of R, imaginary parts |
| tk_re | input | 32 | Column k of T, real parts, row r at bits r*8 |
| tk_im | input | 32 | Column k of T, imaginary parts |
| tl_re | input | 32 | Column l of T, real parts |
| tl_im | input | 32 | Column l of T, imaginary parts |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken when high together with out_valid |
| rk_re_o | output | 64 | Reduced column k of R, real parts |
| rk_im_o | output | 64 | Reduced column k of R, imaginary parts |
| tk_re_o | output | 32 | Reduced column k of T, real parts |
| tk_im_o | output | 32 | Reduced column k of T, imaginary parts |

## Verification
The quantizer is driven with off-diagonal values placed exactly on and one step past both thresholds, with both pivot signs. This separates a strict from a non-strict comparison and shows whether the sign is handled correctly. Random columns with random pivot rows check the cross terms of the complex update. Sweeping piv_idx across all rows shows where the row mask stops. Operands chosen to overflow in both directions show saturation rather than wrap-around. Streaming at full rate and under random output stall separates correct hold behaviour from lost or repeated results.

// File: rtl/szr_pkg.sv
package szr_pkg;
  // steering bits for one coefficient component
  typedef struct packed {
    logic one;  // |x| above half the pivot
    logic two;  // |x| above three halves of the pivot
    logic neg;  // signs differ
  } coef_t;
endpackage

// File: rtl/szr_rst_sync.sv
module szr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_s = stage_q[1];
endmodule

// File: rtl/szr_quant.sv
module szr_quant
  import szr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic signed [W-1:0] num,
  input  logic signed [W-1:0] den,
  output coef_t               c
);
  localparam int AW = W + 3;

  logic signed [AW-1:0] sn, sd;
  logic        [AW-1:0] an, ad, twice_n, thrice_d;

  always_comb begin
    sn       = AW'(num);
    sd       = AW'(den);
    an       = (sn < 0) ? -sn : sn;
    ad       = (sd < 0) ? -sd : sd;
    twice_n  = an << 1;
    thrice_d = ad + (ad << 1);
    c.one    = twice_n > ad;
    c.two    = twice_n > thrice_d;
    c.neg    = num[W-1] ^ den[W-1];
  end
endmodule

// File: rtl/szr_lane.sv
module szr_lane
  import szr_pkg::*;
#(
  parameter int W     = 16,
  parameter bit SUB_V = 1'b0
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] u,
  input  logic signed [W-1:0] v,
  input  coef_t               cu,
  input  coef_t               cv,
  input  logic                en,
  output logic signed [W-1:0] y
);
  localparam int SW   = W + 4;
  localparam int MAXI = 2 ** (W - 1) - 1;
  localparam logic signed [SW-1:0] MAXV = SW'(MAXI);
  localparam logic signed [SW-1:0] MINV = SW'(-MAXI - 1);

  function automatic logic signed [SW-1:0] scaled(input logic signed [W-1:0] b,
                                                  input coef_t c);
    logic signed [SW-1:0] be, mag;
    be  = SW'(b);
    mag = c.two ? (be <<< 1) : (c.one ? be : '0);
    return c.neg ? -mag : mag;
  endfunction

  logic signed [SW-1:0] acc;

  always_comb begin
    acc = SW'(a) - scaled(u, cu);
    if (SUB_V) acc = acc - scaled(v, cv);
    else       acc = acc + scaled(v, cv);
    if (!en)              y = a;
    else if (acc > MAXV)  y = MAXV[W-1:0];
    else if (acc < MINV)  y = MINV[W-1:0];
    else                  y = acc[W-1:0];
  end
endmodule

// File: rtl/szr_unit.sv
module szr_unit
  import szr_pkg::*;
#(
  parameter int N  = 4,
  parameter int W  = 16,
  parameter int TW = 8,
  localparam int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IW-1:0]   piv_idx,
  input  logic [N*W-1:0]  rk_re,
  input  logic [N*W-1:0]  rk_im,
  input  logic [N*W-1:0]  rl_re,
  input  logic [N*W-1:0]  rl_im,
  input  logic [N*TW-1:0] tk_re,
  input  logic [N*TW-1:0] tk_im,
  input  logic [N*TW-1:0] tl_re,
  input  logic [N*TW-1:0] tl_im,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [N*W-1:0]  rk_re_o,
  output logic [N*W-1:0]  rk_im_o,
  output logic [N*TW-1:0] tk_re_o,
  output logic [N*TW-1:0] tk_im_o
);
  logic rst_s;
  szr_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_s(rst_s));

  // pivot and off-diagonal picked out of the columns
  logic signed [W-1:0] pivot, off_re, off_im;
  coef_t c_re, c_im;

  always_comb begin
    pivot  = rl_re[piv_idx*W +: W];
    off_re = rk_re[piv_idx*W +: W];
    off_im = rk_im[piv_idx*W +: W];
  end

  szr_quant #(.W(W)) i_q_re (.num(off_re), .den(pivot), .c(c_re));
  szr_quant #(.W(W)) i_q_im (.num(off_im), .den(pivot), .c(c_im));

  logic [N*W-1:0]  nxt_re, nxt_im;
  logic [N*TW-1:0] nxt_tre, nxt_tim;

  for (genvar r = 0; r < N; r++) begin : g_row
    logic row_en;
    assign row_en = (IW'(r) <= piv_idx);

    szr_lane #(.W(W), .SUB_V(1'b0)) i_r_re (
      .a(rk_re[r*W +: W]), .u(rl_re[r*W +: W]), .v(rl_im[r*W +: W]),
      .cu(c_re), .cv(c_im), .en(row_en), .y(nxt_re[r*W +: W]));
    szr_lane #(.W(W), .SUB_V(1'b1)) i_r_im (
      .a(rk_im[r*W +: W]), .u(rl_im[r*W +: W]), .v(rl_re[r*W +: W]),
      .cu(c_re), .cv(c_im), .en(row_en), .y(nxt_im[r*W +: W]));
    szr_lane #(.W(TW), .SUB_V(1'b0)) i_t_re (
      .a(tk_re[r*TW +: TW]), .u(tl_re[r*TW +: TW]), .v(tl_im[r*TW +: TW]),
      .cu(c_re), .cv(c_im), .en(1'b1), .y(nxt_tre[r*TW +: TW]));
    szr_lane #(.W(TW), .SUB_V(1'b1)) i_t_im (
      .a(tk_im[r*TW +: TW]), .u(tl_im[r*TW +: TW]), .v(tl_re[r*TW +: TW]),
      .cu(c_re), .cv(c_im), .en(1'b1), .y(nxt_tim[r*TW +: TW]));

    // R5
    keep_rows_chk: assert property (@(posedge clk) disable iff (!rst_s)
      (in_valid && in_ready && (piv_idx < IW'(r))) |=>
      (rk_re_o[r*W +: W] == $past(rk_re[r*W +: W])) &&
      (rk_im_o[r*W +: W] == $past(rk_im[r*W +: W])));
  end

  // handshake: next-state and register processes
  logic load, vld_d, vld_q;

  always_comb begin
    in_ready = !vld_q || out_ready;
    load     = in_valid && in_ready;
    if (load)           vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
    else                vld_d = vld_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      rk_re_o <= nxt_re;
      rk_im_o <= nxt_im;
      tk_re_o <= nxt_tre;
      tk_im_o <= nxt_tim;
    end
  end

  assign out_valid = vld_q;

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (in_valid && in_ready) |=> out_valid);

  // R8
  drain_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (out_valid && !out_ready) |=> out_valid && $stable(rk_re_o) &&
    $stable(rk_im_o) && $stable(tk_re_o) && $stable(tk_im_o));
endmodule

// File: tb/test_szr_unit.sv
module test_szr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4, W = 16, TW = 8, IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [IW-1:0] piv_idx = '0;
  logic [N*W-1:0]  rk_re = '0, rk_im = '0, rl_re = '0, rl_im = '0;
  logic [N*TW-1:0] tk_re = '0, tk_im = '0, tl_re = '0, tl_im = '0;
  logic [N*W-1:0]  rk_re_o, rk_im_o;
  logic [N*TW-1:0] tk_re_o, tk_im_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  szr_unit i_szr_unit (.*);

  typedef struct {
    logic [N*W-1:0]  re, im;
    logic [N*TW-1:0] tre, tim;
  } exp_t;

  exp_t  q[$];
  int    checks = 0, errors = 0;
  string tag = "R3,R4";
  bit    live = 0, bp_mode = 0, done = 0;
  int    akre[N], akim[N], alre[N], alim[N], atkre[N], atkim[N], atlre[N], atlim[N];

  function automatic int sat(int v, int w);
    int mx = (1 << (w - 1)) - 1;
    if (v > mx) return mx;
    if (v < -mx - 1) return -mx - 1;
    return v;
  endfunction

  function automatic int qc(int x, int p);
    int ax = (x < 0) ? -x : x;
    int ap = (p < 0) ? -p : p;
    int m  = int'(2 * ax > ap) + int'(2 * ax > 3 * ap);
    return ((x < 0) != (p < 0)) ? -m : m;
  endfunction

  function automatic exp_t model();
    exp_t e;
    int p, mr, mi, pi;
    pi = int'(piv_idx);
    p  = int'($signed(rl_re[pi*W +: W]));
    mr = qc(int'($signed(rk_re[pi*W +: W])), p);
    mi = qc(int'($signed(rk_im[pi*W +: W])), p);
    for (int r = 0; r < N; r++) begin
      int are, aim, bre, bim, tar, tai, tbr, tbi, vre, vim;
      are = int'($signed(rk_re[r*W +: W]));  aim = int'($signed(rk_im[r*W +: W]));
      bre = int'($signed(rl_re[r*W +: W]));  bim = int'($signed(rl_im[r*W +: W]));
      tar = int'($signed(tk_re[r*TW +: TW])); tai = int'($signed(tk_im[r*TW +: TW]));
      tbr = int'($signed(tl_re[r*TW +: TW])); tbi = int'($signed(tl_im[r*TW +: TW]));
      vre = (r <= pi) ? sat(are - (mr * bre - mi * bim), W) : are;
      vim = (r <= pi) ? sat(aim - (mr * bim + mi * bre), W) : aim;
      e.re[r*W +: W]   = vre[W-1:0];
      e.im[r*W +: W]   = vim[W-1:0];
      vre = sat(tar - (mr * tbr - mi * tbi), TW);
      vim = sat(tai - (mr * tbi + mi * tbr), TW);
      e.tre[r*TW +: TW] = vre[TW-1:0];
      e.tim[r*TW +: TW] = vim[TW-1:0];
    end
    return e;
  endfunction

  task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, expv);
    end
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin
    if (live) begin
      bit ev;
      ev = (q.size() > 0);
      chk(out_valid == ev, "R8 out_valid", 64'(out_valid), 64'(ev));
      chk(in_ready == (!ev || out_ready), "R9 in_ready", 64'(in_ready), 64'(!ev || out_ready));
      if (ev && out_valid) begin
        chk(rk_re_o == q[0].re,  {tag, " R3 real lane"}, rk_re_o, q[0].re);
        chk(rk_im_o == q[0].im,  {tag, " R4 imag lane"}, rk_im_o, q[0].im);
        chk(tk_re_o == q[0].tre, {tag, " R6 T real"}, 64'(tk_re_o), 64'(q[0].tre));
        chk(tk_im_o == q[0].tim, {tag, " R6 T imag"}, 64'(tk_im_o), 64'(q[0].tim));
      end
      if (ev && out_ready) void'(q.pop_front());
      if (in_valid && (!ev || out_ready)) q.push_back(model());
    end
  end

  always @(posedge clk) begin
    #1 out_ready <= bp_mode ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  task automatic apply(int piv);
    piv_idx = IW'(piv);
    for (int r = 0; r < N; r++) begin
      rk_re[r*W +: W] = akre[r][W-1:0];    rk_im[r*W +: W] = akim[r][W-1:0];
      rl_re[r*W +: W] = alre[r][W-1:0];    rl_im[r*W +: W] = alim[r][W-1:0];
      tk_re[r*TW +: TW] = atkre[r][TW-1:0]; tk_im[r*TW +: TW] = atkim[r][TW-1:0];
      tl_re[r*TW +: TW] = atlre[r][TW-1:0]; tl_im[r*TW +: TW] = atlim[r][TW-1:0];
    end
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
  endtask

  task automatic fill_rand(int rr, int tr);
    for (int r = 0; r < N; r++) begin
      akre[r] = $urandom_range(0, 2 * rr) - rr;  akim[r] = $urandom_range(0, 2 * rr) - rr;
      alre[r] = $urandom_range(0, 2 * rr) - rr;  alim[r] = $urandom_range(0, 2 * rr) - rr;
      atkre[r] = $urandom_range(0, 2 * tr) - tr; atkim[r] = $urandom_range(0, 2 * tr) - tr;
      atlre[r] = $urandom_range(0, 2 * tr) - tr; atlim[r] = $urandom_range(0, 2 * tr) - tr;
    end
  endtask

  task automatic finish_phase();
    in_valid = 1'b0;
    while (q.size() > 0) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int xs[8] = '{50, 51, 150, 151, -51, -151, 0, 300};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", 64'(in_ready), 64'd1);
    live = 1;
    @(posedge clk); #1;

    // R2: threshold corners, both pivot signs
    tag = "R2";
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 8; i++) begin
        fill_rand(500, 20);
        alre[1] = s ? -100 : 100;
        akre[1] = xs[i];
        akim[1] = xs[7 - i];
        apply(1);
      end
    finish_phase();

    // R3, R4: random columns and pivot rows
    tag = "R3,R4";
    for (int i = 0; i < 30; i++) begin
      int pv = $urandom_range(0, N - 1);
      fill_rand(2000, 30);
      apply(pv);
    end
    finish_phase();

    // R5: each pivot row
    tag = "R5";
    for (int pv = 0; pv < N; pv++) begin
      fill_rand(3000, 30);
      alre[pv] = 700;
      akre[pv] = 1600;
      akim[pv] = -900;
      apply(pv);
    end
    finish_phase();

    // R6: T lane with larger coefficients
    tag = "R6";
    for (int i = 0; i < 10; i++) begin
      fill_rand(1000, 25);
      alre[0] = 200;
      akre[0] = (i % 2) ? 450 : -250;
      akim[0] = (i % 3) ? -320 : 120;
      apply(0);
    end
    finish_phase();

    // R7: saturation both ways
    tag = "R7";
    fill_rand(10, 5);
    alre[0] = 1000; akre[0] = 32000; akim[0] = 0;
    akre[1] = 32000;  alre[1] = -30000; alim[1] = 0;
    akre[2] = -32000; alre[2] = 30000;  alim[2] = 0;
    akim[3] = 30000;  alim[3] = -20000;
    atkre[0] = 100; atlre[0] = -100; atkre[1] = -100; atlre[1] = 100;
    apply(3);
    fill_rand(10, 5);
    alre[1] = -50; akre[1] = 32000; akim[1] = -32000;
    alre[0] = 32000; alim[0] = -32000; akre[0] = 30000; akim[0] = 30000;
    atkim[2] = 120; atlim[2] = 120; atlre[2] = 120;
    apply(1);
    finish_phase();

    // R8: back-to-back stream
    tag = "R8";
    for (int i = 0; i < 40; i++) begin
      fill_rand(5000, 40);
      apply($urandom_range(0, N - 1));
    end
    finish_phase();

    // R9: random output stall
    tag = "R9";
    bp_mode = 1;
    for (int i = 0; i < 60; i++) begin
      fill_rand(5000, 40);
      apply($urandom_range(0, N - 1));
    end
    bp_mode = 0;
    finish_phase();

    repeat (3) @(posedge clk);
    summary();
  end
endmodule